// File: doc/BRIEF.md
# Data Toggle Synchronization Checker

This block sits beside a host-side serial interface engine and keeps the DATA0/DATA1 sequence bit of each transaction in order. At the start of a transaction the descriptor side loads a context: the toggle value the endpoint expects, whether the data phase runs device-to-host (IN) or host-to-device (OUT), and whether the endpoint is isochronous. Loading the context arms the block for one transaction.

When a packet finishes, the receive path raises a packet-end strobe together with the packet's PID and an error flag from the CRC, bit-stuff and PID-check stages. For IN data, the block compares the received data PID against the expected toggle. From that comparison it decides whether the data is kept and whether an ACK should be sent, and it tells the descriptor side whether to write back a flipped toggle. For OUT transfers, the block watches the handshake from the device and flips the toggle only when that handshake is an ACK. Isochronous traffic bypasses the comparison entirely.

All results come out of registers one cycle after the packet-end strobe, as single-cycle pulses.

Top module: `toggle_sync_chk`

## Requirements
- R1: A pulse on `desc_load` captures `desc_tog`, `desc_in` and `desc_iso` and arms one transaction. A later load replaces any earlier context, and if it coincides with a packet end, the load wins for the following transaction.
- R2: On an armed, non-isochronous IN transaction without error, a data PID whose bit 3 equals the expected toggle has three effects. It gives `res_valid`, `data_accept`, `ack_req` and `tog_upd` all high. DATA0 is 4'b0011 and DATA1 is 4'b1011.
- R3: On an armed, non-isochronous IN transaction without error, a data PID whose toggle differs from the expected one gives `res_valid` and `ack_req` high, with `data_accept` and `tog_upd` low.
- R4: On an armed, non-isochronous OUT transaction without error, an ACK handshake (4'b0010) gives `res_valid` and `tog_upd`. NAK (4'b1010) or STALL (4'b1110) gives `res_valid` alone. OUT never raises `data_accept` or `ack_req`.
- R5: On an isochronous IN transaction, either data PID gives `res_valid` and `data_accept`, with no `ack_req` and no `tog_upd`. An isochronous OUT handshake gives `res_valid` alone.
- R6: When `pkt_err` is high with an armed packet end, the transaction retires with `res_valid` alone. There is no accept, no ACK request and no toggle update.
- R7: While `tog_upd` is high, `tog_new` is the inverse of the loaded expected toggle. Otherwise `tog_new` is 0.
- R8: Every output is registered. It changes on the first clock edge after the packet-end cycle, and it is 0 in any cycle that does not follow a result.
- R9: A PID that does not fit the armed direction is ignored: no output is produced and the transaction stays armed. For IN, the fitting PIDs are data PIDs; for OUT, they are ACK, NAK and STALL.
- R10: A packet end with no armed transaction produces no output. A transaction that has produced a result is disarmed.
- R11: After reset, all outputs are 0 and no transaction is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Load transaction context and arm |
| desc_tog | input | 1 | Expected toggle for the endpoint |
| desc_in | input | 1 | 1 = IN data phase, 0 = OUT |
| desc_iso | input | 1 | Isochronous endpoint |
| pkt_end | input | 1 | Received packet finished this cycle |
| pkt_pid | input | 4 | PID of the finished packet |
| pkt_err | input | 1 | Error reported by earlier receive stages |
| res_valid | output | 1 | Transaction retired |
| data_accept | output | 1 | Received IN data is kept |
| ack_req | output | 1 | Request ACK to the device |
| tog_upd | output | 1 | Write back a new toggle |
| tog_new | output | 1 | Toggle value to write back |

## Verification
Directed cases cover both toggle values on IN data in both the matching and mismatching sense, which separates a correct compare from a stuck or inverted one. They also cover ACK against NAK and STALL on OUT, which separates handshake decoding from plain packet-end counting. Isochronous cases in both directions show that the comparison is skipped and no write-back occurs. Error-with-match cases show that the error overrides the match. Off-direction PIDs followed by a valid one, packet ends with nothing armed, and a reload on the packet-end cycle exercise the arming rules. A seeded random mix of loads, PIDs, directions and errors then drives the same expected-value function over long sequences.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int PID_W = 4;
    typedef logic [PID_W-1:0] pid_t;

    localparam pid_t PID_DATA0 = 4'b0011;
    localparam pid_t PID_DATA1 = 4'b1011;
    localparam pid_t PID_ACK   = 4'b0010;
    localparam pid_t PID_NAK   = 4'b1010;
    localparam pid_t PID_STALL = 4'b1110;

    // bit of a data PID that carries the toggle
    localparam int TOG_BIT = 3;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_HS    = 2'd2
    } pid_cls_e;

    typedef struct packed {
        logic armed;
        logic tog;
        logic dir_in;
        logic iso;
    } ctx_t;

    typedef struct packed {
        logic valid;
        logic accept;
        logic ack;
        logic upd;
        logic tog;
    } result_t;
endpackage

// File: rtl/tsc_ctx.sv
module tsc_ctx
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_tog,
    input  logic load_in,
    input  logic load_iso,
    input  logic retire,
    output ctx_t ctx
);
    typedef struct packed {
        ctx_t c;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (retire) begin
            state_d.c.armed = 1'b0;
        end
        if (load) begin
            state_d.c.armed  = 1'b1;
            state_d.c.tog    = load_tog;
            state_d.c.dir_in = load_in;
            state_d.c.iso    = load_iso;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctx = state_q.c;

    // R1: a load always leaves the block armed with the loaded toggle
    a_r1_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctx.armed && ctx.tog == $past(load_tog)));

    // R10: a retire without reload disarms
    a_r10_retire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !load) |=> !ctx.armed);
endmodule

// File: rtl/tsc_decide.sv
module tsc_decide
    import tsc_pkg::*;
(
    input  ctx_t    ctx,
    input  logic    pkt_end,
    input  pid_t    pkt_pid,
    input  logic    pkt_err,
    output result_t res,
    output logic    retire
);
    pid_cls_e cls;
    logic     pid_tog;

    always_comb begin
        unique case (pkt_pid)
            PID_DATA0, PID_DATA1:         cls = CLS_DATA;
            PID_ACK, PID_NAK, PID_STALL:  cls = CLS_HS;
            default:                      cls = CLS_OTHER;
        endcase
    end

    assign pid_tog = pkt_pid[TOG_BIT];

    always_comb begin
        res    = '0;
        retire = 1'b0;
        if (pkt_end && ctx.armed) begin
            if (pkt_err) begin
                retire    = 1'b1;
                res.valid = 1'b1;
            end else if (ctx.dir_in && cls == CLS_DATA) begin
                retire    = 1'b1;
                res.valid = 1'b1;
                if (ctx.iso) begin
                    res.accept = 1'b1;
                end else begin
                    res.ack = 1'b1;
                    if (pid_tog == ctx.tog) begin
                        res.accept = 1'b1;
                        res.upd    = 1'b1;
                        res.tog    = ~ctx.tog;
                    end
                end
            end else if (!ctx.dir_in && cls == CLS_HS) begin
                retire    = 1'b1;
                res.valid = 1'b1;
                if (pkt_pid == PID_ACK && !ctx.iso) begin
                    res.upd = 1'b1;
                    res.tog = ~ctx.tog;
                end
            end
        end
    end
endmodule

// File: rtl/toggle_sync_chk.sv
module toggle_sync_chk
    import tsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_load,
    input  logic             desc_tog,
    input  logic             desc_in,
    input  logic             desc_iso,
    input  logic             pkt_end,
    input  logic [PID_W-1:0] pkt_pid,
    input  logic             pkt_err,
    output logic             res_valid,
    output logic             data_accept,
    output logic             ack_req,
    output logic             tog_upd,
    output logic             tog_new
);
    ctx_t    ctx;
    result_t dec_res;
    logic    retire;

    typedef struct packed {
        result_t r;
    } state_t;

    state_t state_d, state_q;

    tsc_ctx u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (desc_load),
        .load_tog (desc_tog),
        .load_in  (desc_in),
        .load_iso (desc_iso),
        .retire   (retire),
        .ctx      (ctx)
    );

    tsc_decide u_decide (
        .ctx     (ctx),
        .pkt_end (pkt_end),
        .pkt_pid (pkt_pid),
        .pkt_err (pkt_err),
        .res     (dec_res),
        .retire  (retire)
    );

    always_comb begin
        state_d   = state_q;
        state_d.r = dec_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid   = state_q.r.valid;
    assign data_accept = state_q.r.accept;
    assign ack_req     = state_q.r.ack;
    assign tog_upd     = state_q.r.upd;
    assign tog_new     = state_q.r.tog;

    // R2: matching IN data is kept, acknowledged and flips the toggle
    a_r2_match_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && ctx.armed && ctx.dir_in && !ctx.iso && !pkt_err &&
         (pkt_pid == PID_DATA0 || pkt_pid == PID_DATA1) &&
         pkt_pid[TOG_BIT] == ctx.tog)
        |=> (data_accept && ack_req && tog_upd));

    // R3: mismatched IN data is acknowledged but dropped
    a_r3_mismatch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && ctx.armed && ctx.dir_in && !ctx.iso && !pkt_err &&
         (pkt_pid == PID_DATA0 || pkt_pid == PID_DATA1) &&
         pkt_pid[TOG_BIT] != ctx.tog)
        |=> (ack_req && !data_accept && !tog_upd));

    // R4: OUT never requests ACK nor accepts data
    a_r4_out_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && ctx.armed && !ctx.dir_in) |=> (!ack_req && !data_accept));

    // R5: isochronous never updates the toggle nor requests ACK
    a_r5_iso_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && ctx.armed && ctx.iso) |=> (!tog_upd && !ack_req));

    // R6: an error suppresses ACK, accept and update
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && pkt_err) |=> (!ack_req && !tog_upd && !data_accept));

    // R7: the written-back toggle is the inverse of the expected one
    a_r7_new_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        tog_upd |-> (tog_new == !$past(ctx.tog)));

    // R8: any result implies a retired transaction
    a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (data_accept || ack_req || tog_upd) |-> res_valid);

    // R10: nothing armed, nothing reported
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_end && ctx.armed) |=> !res_valid);
endmodule

// File: tb/toggle_sync_chk_tb.sv
module toggle_sync_chk_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] D0 = 4'b0011, D1 = 4'b1011, ACK = 4'b0010,
                           NAK = 4'b1010, STALL = 4'b1110, BAD = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_load = 0, desc_tog = 0, desc_in = 0, desc_iso = 0;
    logic pkt_end = 0, pkt_err = 0;
    logic [3:0] pkt_pid = '0;
    logic res_valid, data_accept, ack_req, tog_upd, tog_new;

    int total = 0;
    int bad = 0;
    logic m_armed = 0, m_tog = 0, m_in = 0, m_iso = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toggle_sync_chk u_dut (
        .clk(clk), .rst_n(rst_n),
        .desc_load(desc_load), .desc_tog(desc_tog), .desc_in(desc_in), .desc_iso(desc_iso),
        .pkt_end(pkt_end), .pkt_pid(pkt_pid), .pkt_err(pkt_err),
        .res_valid(res_valid), .data_accept(data_accept), .ack_req(ack_req),
        .tog_upd(tog_upd), .tog_new(tog_new)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // called at a negedge; drives one cycle, samples at the next negedge
    task automatic step(input logic ld, input logic t, input logic di, input logic is,
                        input logic pe, input logic [3:0] p, input logic e);
        logic [4:0] exp;
        logic ret;
        logic isdata, ishs;
        string tag;
        desc_load = ld; desc_tog = t; desc_in = di; desc_iso = is;
        pkt_end = pe; pkt_pid = p; pkt_err = e;
        exp = '0; ret = 0; tag = "R8";
        isdata = (p == D0) || (p == D1);
        ishs = (p == ACK) || (p == NAK) || (p == STALL);
        if (pe) begin
            if (!m_armed) tag = "R10";
            else if (e) begin exp = 5'b10000; ret = 1; tag = "R6"; end
            else if (m_in && isdata) begin
                ret = 1;
                if (m_iso) begin exp = 5'b11000; tag = "R5"; end
                else if (p[3] == m_tog) begin exp = {4'b1111, ~m_tog}; tag = "R2"; end
                else begin exp = 5'b10100; tag = "R3"; end
            end else if (!m_in && ishs) begin
                ret = 1;
                if (p == ACK && !m_iso) begin exp = {4'b1001, ~m_tog}; tag = "R4"; end
                else begin exp = 5'b10000; tag = m_iso ? "R5" : "R4"; end
            end else tag = "R9";
        end
        if (ret) m_armed = 0;
        if (ld) begin m_armed = 1; m_tog = t; m_in = di; m_iso = is; end
        @(negedge clk);
        check(tag, {res_valid, data_accept, ack_req, tog_upd, tog_new}, exp);
        if (exp[1]) check("R7", {4'b0, tog_new}, {4'b0, exp[0]});
        desc_load = 0; pkt_end = 0; pkt_err = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", {res_valid, data_accept, ack_req, tog_upd, tog_new}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: packet end with nothing armed
        step(0, 0, 0, 0, 1, D0, 0);
        // R2 / R7 with both toggles
        step(1, 0, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D0, 0);
        step(1, 1, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D1, 0);
        // R3 mismatch both ways
        step(1, 0, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D1, 0);
        step(1, 1, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D0, 0);
        // R10: retired transaction disarmed
        step(0, 0, 0, 0, 1, D0, 0);
        // R4 OUT handshakes
        step(1, 1, 0, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, ACK, 0);
        step(1, 0, 0, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, NAK, 0);
        step(1, 0, 0, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, STALL, 0);
        // R5 isochronous
        step(1, 0, 1, 1, 0, D0, 0);
        step(0, 0, 0, 0, 1, D1, 0);
        step(1, 1, 1, 1, 0, D0, 0);
        step(0, 0, 0, 0, 1, D0, 0);
        step(1, 0, 0, 1, 0, D0, 0);
        step(0, 0, 0, 0, 1, ACK, 0);
        // R6 error overrides a match
        step(1, 0, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D0, 1);
        // R9 off-direction PIDs ignored, stays armed
        step(1, 1, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, ACK, 0);
        step(0, 0, 0, 0, 1, BAD, 0);
        step(0, 0, 0, 0, 1, D1, 0);
        step(1, 0, 0, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D1, 0);
        step(0, 0, 0, 0, 1, ACK, 0);
        // R1: reload replaces context, and wins on a packet-end cycle
        step(1, 0, 1, 0, 0, D0, 0);
        step(1, 1, 1, 0, 0, D0, 0);
        step(0, 0, 0, 0, 1, D1, 0);
        step(1, 0, 1, 0, 0, D0, 0);
        step(1, 1, 0, 0, 1, D0, 0);
        step(0, 0, 0, 0, 1, ACK, 0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] p;
            case ($urandom % 6)
                0: p = D0; 1: p = D1; 2: p = ACK; 3: p = NAK; 4: p = STALL;
                default: p = BAD;
            endcase
            step(($urandom % 3) == 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
                 $urandom % 2, p, ($urandom % 8) == 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule